// File: doc/BRIEF.md
# I2C Bus Timing Compliance Monitor

This block watches the SCL and SDA wires of an I2C bus and never drives them. It brings both lines into the fast system clock domain and finds the edges and the START and STOP conditions. It measures the time, in system-clock cycles, between pairs of related bus events. It then compares each interval with a minimum limit for a fast-mode-plus class target. Each limit is an integer cycle-count parameter. With a 100 MHz clock the resolution is 10 ns.

The block keeps one sticky flag for each timing rule. When a rule is broken, it records a 4-bit code and raises a one-cycle strobe. The rule for data hold depends on who drives the bus. When the local side is transmitting, the hold time must fall inside a window. Otherwise only a minimum applies. A pulse on `resetDone` opens a quiet period, and a START inside that period is reported. The block does not decode bytes or addresses and does not check rise or fall times.

Top module: `i2c_timing_monitor`

## Requirements
- R1: An SCL high phase (rise to the next fall) shorter than MIN_HIGH cycles sets flag bit 0.
- R2: An SCL low phase (fall to the next rise) shorter than MIN_LOW cycles sets flag bit 1.
- R3: Two consecutive SCL rising edges closer than MIN_PERIOD cycles set flag bit 10.
- R4: A START that comes less than MIN_FREE cycles after the preceding STOP sets flag bit 2. A START is SDA falling while SCL stays high. A STOP is SDA rising while SCL stays high.
- R5: The first SCL fall after a START, if it comes less than MIN_STA_HD cycles after that START, sets flag bit 3.
- R6: A START less than MIN_STA_SU cycles after the last SCL rise sets flag bit 4. A STOP less than MIN_STO_SU cycles after the last SCL rise sets flag bit 5.
- R7: An SCL rise less than MIN_DAT_SU cycles after the last SDA change sets flag bit 6. An SDA change in the same cycle as the rise counts as 0 cycles.
- R8: While `localTx` is 0, the first SDA change during an SCL low phase that comes less than MIN_DAT_HD cycles after the SCL fall sets flag bit 7.
- R9: While `localTx` is 1, that same hold interval must lie in the range TX_HD_MIN to TX_HD_MAX, both ends included. Outside that range it sets flag bit 8, and flag bit 7 is not set.
- R10: A START less than QUIET_CYC cycles after a `resetDone` pulse sets flag bit 9. The interval counts from the edge that samples `resetDone` to the edge that samples the raw SDA change. Until the first pulse, no START triggers this rule.
- R11: After reset, all flags, `violCode` and `violStrobe` are 0. A flag, once set, stays set until the next reset.
- R12: In every cycle where at least one rule fires, `violStrobe` is high for one cycle and `violCode` takes the value (bit index + 1) of the lowest-numbered rule that fired. This happens on the third rising edge after the raw line change that caused it. `violCode` holds that value until the next violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw SCL level from the bus |
| sdaIn | input | 1 | Raw SDA level from the bus |
| resetDone | input | 1 | One-cycle pulse that opens the quiet window after reset |
| localTx | input | 1 | 1 while the local side drives data onto SDA |
| violFlags | output | 11 | Sticky flag for each rule, bit numbering as in the requirements |
| violCode | output | 4 | Code of the most recent violation, 0 if none |
| violStrobe | output | 1 | One-cycle pulse for each cycle in which a rule fires |

## Verification
Most internal faults show up as a flag that is wrong in a specific bus pattern. Examples are a counter that restarts on the wrong edge, a misplaced arm bit, or an off-by-one limit compare. Such a fault appears at `violFlags` no more than three cycles after the offending edge, so sweeping each interval across its limit reveals it. A fault in the alignment between SDA, SCL and `resetDone` moves the pass/fail boundary by a whole cycle. Checking the intervals on both sides of each limit catches this. A fault in the code priority or the strobe pipeline shows in `violCode` and in the exact cycle of `violStrobe`.

// File: rtl/i2c_tmon_pkg.sv
package i2c_tmon_pkg;

  localparam int NUM_RULES = 11;
  localparam int CODE_W    = 4;

  // rule bit positions (code = position + 1, lower code wins on ties)
  localparam int RULE_HIGH   = 0;
  localparam int RULE_LOW    = 1;
  localparam int RULE_FREE   = 2;
  localparam int RULE_STA_HD = 3;
  localparam int RULE_STA_SU = 4;
  localparam int RULE_STO_SU = 5;
  localparam int RULE_DAT_SU = 6;
  localparam int RULE_DAT_HD = 7;
  localparam int RULE_TX_HD  = 8;
  localparam int RULE_QUIET  = 9;
  localparam int RULE_PERIOD = 10;

  // elapsed-time counters kept on bus events
  localparam int CNT_RISE    = 0;
  localparam int CNT_FALL    = 1;
  localparam int CNT_SDA     = 2;
  localparam int CNT_START   = 3;
  localparam int CNT_STOP    = 4;
  localparam int NUM_BUS_CNT = 5;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic sdaChg;
    logic start;
    logic stop;
    logic sclLvl;
  } busEvt_t;

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // width whose saturated value exceeds lim
  function automatic int unsigned satWidth(input int unsigned lim);
    return $clog2(lim + 2);
  endfunction

endpackage

// File: rtl/i2c_tmon_since.sv
module i2c_tmon_since #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         restart,
  output logic [W-1:0] count
);

  // cycles since the last restart; saturates, starts saturated
  always_ff @(posedge clk) begin
    if (!rstN)              count <= '1;
    else if (restart)       count <= W'(1);
    else if (count != '1)   count <= count + 1'b1;
  end

endmodule

// File: rtl/i2c_tmon_dp.sv
module i2c_tmon_dp
  import i2c_tmon_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned RST_W = 20
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  sclIn,
  input  logic                                  sdaIn,
  input  logic                                  resetDone,
  output busEvt_t                               evt,
  output logic [NUM_BUS_CNT-1:0][CNT_W-1:0]     since,
  output logic [RST_W-1:0]                      sinceRst
);

  logic [1:0] sclSync, sdaSync, rdPipe;
  logic       sclPrev, sdaPrev, sclS, sdaS;
  logic [NUM_BUS_CNT-1:0] restart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      rdPipe  <= 2'b00;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
      // same two-stage lag as the bus lines so intervals line up
      rdPipe  <= {rdPipe[0], resetDone};
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_comb begin
    evt.sclRise = sclS & ~sclPrev;
    evt.sclFall = ~sclS & sclPrev;
    evt.sdaChg  = sdaS ^ sdaPrev;
    evt.start   = sclS & sclPrev & ~sdaS & sdaPrev;
    evt.stop    = sclS & sclPrev & sdaS & ~sdaPrev;
    evt.sclLvl  = sclS;
  end

  always_comb begin
    restart            = '0;
    restart[CNT_RISE]  = evt.sclRise;
    restart[CNT_FALL]  = evt.sclFall;
    restart[CNT_SDA]   = evt.sdaChg;
    restart[CNT_START] = evt.start;
    restart[CNT_STOP]  = evt.stop;
  end

  for (genvar g = 0; g < NUM_BUS_CNT; g++) begin : g_cnt
    i2c_tmon_since #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .restart (restart[g]),
      .count   (since[g])
    );
  end

  i2c_tmon_since #(.W(RST_W)) u_rstCnt (
    .clk     (clk),
    .rstN    (rstN),
    .restart (rdPipe[1]),
    .count   (sinceRst)
  );

endmodule

// File: rtl/i2c_tmon_ctrl.sv
module i2c_tmon_ctrl
  import i2c_tmon_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned RST_W      = 20,
  parameter int unsigned MIN_HIGH   = 30,
  parameter int unsigned MIN_LOW    = 65,
  parameter int unsigned MIN_FREE   = 65,
  parameter int unsigned MIN_STA_HD = 30,
  parameter int unsigned MIN_STA_SU = 30,
  parameter int unsigned MIN_STO_SU = 30,
  parameter int unsigned MIN_DAT_SU = 10,
  parameter int unsigned MIN_DAT_HD = 8,
  parameter int unsigned TX_HD_MIN  = 25,
  parameter int unsigned TX_HD_MAX  = 35,
  parameter int unsigned MIN_PERIOD = 125,
  parameter int unsigned QUIET_CYC  = 500000
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  busEvt_t                           evt,
  input  logic [NUM_BUS_CNT-1:0][CNT_W-1:0] since,
  input  logic [RST_W-1:0]                  sinceRst,
  input  logic                              localTx,
  output logic [NUM_RULES-1:0]              violFlags,
  output logic [CODE_W-1:0]                 violCode,
  output logic                              violStrobe
);

  localparam logic [CNT_W-1:0] L_HIGH   = CNT_W'(MIN_HIGH);
  localparam logic [CNT_W-1:0] L_LOW    = CNT_W'(MIN_LOW);
  localparam logic [CNT_W-1:0] L_FREE   = CNT_W'(MIN_FREE);
  localparam logic [CNT_W-1:0] L_STA_HD = CNT_W'(MIN_STA_HD);
  localparam logic [CNT_W-1:0] L_STA_SU = CNT_W'(MIN_STA_SU);
  localparam logic [CNT_W-1:0] L_STO_SU = CNT_W'(MIN_STO_SU);
  localparam logic [CNT_W-1:0] L_DAT_SU = CNT_W'(MIN_DAT_SU);
  localparam logic [CNT_W-1:0] L_DAT_HD = CNT_W'(MIN_DAT_HD);
  localparam logic [CNT_W-1:0] L_TX_LO  = CNT_W'(TX_HD_MIN);
  localparam logic [CNT_W-1:0] L_TX_HI  = CNT_W'(TX_HD_MAX);
  localparam logic [CNT_W-1:0] L_PERIOD = CNT_W'(MIN_PERIOD);
  localparam logic [RST_W-1:0] L_QUIET  = RST_W'(QUIET_CYC);

  logic                 staArm, holdArm, holdHit;
  logic [CNT_W-1:0]     sdaGap, holdVal;
  logic [NUM_RULES-1:0] hit;
  logic [CODE_W-1:0]    firstCode;

  // arm bits: first fall after START, first SDA change in a low phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      staArm  <= 1'b0;
      holdArm <= 1'b0;
    end else begin
      if (evt.start)        staArm <= 1'b1;
      else if (evt.sclFall) staArm <= 1'b0;

      if (evt.sclFall)                     holdArm <= ~evt.sdaChg;
      else if (evt.sclRise || evt.sdaChg)  holdArm <= 1'b0;
    end
  end

  always_comb begin
    sdaGap  = evt.sdaChg  ? '0 : since[CNT_SDA];
    holdVal = evt.sclFall ? '0 : since[CNT_FALL];
    holdHit = evt.sdaChg & ~evt.sclLvl & (holdArm | evt.sclFall);

    hit              = '0;
    hit[RULE_HIGH]   = evt.sclFall & (since[CNT_RISE] < L_HIGH);
    hit[RULE_LOW]    = evt.sclRise & (since[CNT_FALL] < L_LOW);
    hit[RULE_PERIOD] = evt.sclRise & (since[CNT_RISE] < L_PERIOD);
    hit[RULE_FREE]   = evt.start   & (since[CNT_STOP] < L_FREE);
    hit[RULE_STA_HD] = evt.sclFall & staArm & (since[CNT_START] < L_STA_HD);
    hit[RULE_STA_SU] = evt.start   & (since[CNT_RISE] < L_STA_SU);
    hit[RULE_STO_SU] = evt.stop    & (since[CNT_RISE] < L_STO_SU);
    hit[RULE_DAT_SU] = evt.sclRise & (sdaGap < L_DAT_SU);
    hit[RULE_DAT_HD] = holdHit & ~localTx & (holdVal < L_DAT_HD);
    hit[RULE_TX_HD]  = holdHit &  localTx & ((holdVal < L_TX_LO) | (holdVal > L_TX_HI));
    hit[RULE_QUIET]  = evt.start   & (sinceRst < L_QUIET);
  end

  // lowest-numbered rule wins the code
  always_comb begin
    firstCode = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hit[i]) firstCode = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violFlags  <= '0;
      violCode   <= '0;
      violStrobe <= 1'b0;
    end else begin
      violFlags  <= violFlags | hit;
      violStrobe <= |hit;
      if (|hit) violCode <= firstCode;
    end
  end

  // R11: flags never drop without reset
  p_sticky_keep_r11: assert property (@(posedge clk) disable iff (!rstN)
    (violFlags != '0) |=> ((violFlags & $past(violFlags)) == $past(violFlags)));

  // R12: a strobe always carries a legal nonzero code
  p_strobe_code_r12: assert property (@(posedge clk) disable iff (!rstN)
    violStrobe |-> ((violCode != '0) && (violCode <= CODE_W'(NUM_RULES))));

  // R12: a nonzero code implies some flag is recorded
  p_code_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    (violCode != '0) |-> (violFlags != '0));

  // R8: hold tracking is only armed while the datapath sees SCL low
  p_hold_arm_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    holdArm |-> (!evt.sclLvl || evt.sclRise));

  // R5: START-hold tracking only armed while SCL remains high
  p_sta_arm_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    staArm |-> (evt.sclLvl || evt.sclFall));

endmodule

// File: rtl/i2c_timing_monitor.sv
module i2c_timing_monitor
  import i2c_tmon_pkg::*;
#(
  parameter int unsigned MIN_HIGH   = 30,
  parameter int unsigned MIN_LOW    = 65,
  parameter int unsigned MIN_FREE   = 65,
  parameter int unsigned MIN_STA_HD = 30,
  parameter int unsigned MIN_STA_SU = 30,
  parameter int unsigned MIN_STO_SU = 30,
  parameter int unsigned MIN_DAT_SU = 10,
  parameter int unsigned MIN_DAT_HD = 8,
  parameter int unsigned TX_HD_MIN  = 25,
  parameter int unsigned TX_HD_MAX  = 35,
  parameter int unsigned MIN_PERIOD = 125,
  parameter int unsigned QUIET_CYC  = 500000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 resetDone,
  input  logic                 localTx,
  output logic [10:0]          violFlags,
  output logic [3:0]           violCode,
  output logic                 violStrobe
);

  localparam int unsigned MAX_BUS_LIM =
    maxU(maxU(maxU(MIN_HIGH, MIN_LOW), maxU(MIN_FREE, MIN_PERIOD)),
         maxU(maxU(MIN_STA_HD, MIN_STA_SU),
              maxU(MIN_STO_SU, maxU(MIN_DAT_SU, maxU(MIN_DAT_HD, TX_HD_MAX)))));
  localparam int unsigned CNT_W = satWidth(MAX_BUS_LIM);
  localparam int unsigned RST_W = satWidth(QUIET_CYC);

  busEvt_t                           evt;
  logic [NUM_BUS_CNT-1:0][CNT_W-1:0] since;
  logic [RST_W-1:0]                  sinceRst;

  i2c_tmon_dp #(.CNT_W(CNT_W), .RST_W(RST_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .resetDone (resetDone),
    .evt       (evt),
    .since     (since),
    .sinceRst  (sinceRst)
  );

  i2c_tmon_ctrl #(
    .CNT_W(CNT_W), .RST_W(RST_W),
    .MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW), .MIN_FREE(MIN_FREE),
    .MIN_STA_HD(MIN_STA_HD), .MIN_STA_SU(MIN_STA_SU), .MIN_STO_SU(MIN_STO_SU),
    .MIN_DAT_SU(MIN_DAT_SU), .MIN_DAT_HD(MIN_DAT_HD),
    .TX_HD_MIN(TX_HD_MIN), .TX_HD_MAX(TX_HD_MAX),
    .MIN_PERIOD(MIN_PERIOD), .QUIET_CYC(QUIET_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .since      (since),
    .sinceRst   (sinceRst),
    .localTx    (localTx),
    .violFlags  (violFlags),
    .violCode   (violCode),
    .violStrobe (violStrobe)
  );

endmodule

// File: tb/sim_i2c_timing_monitor.sv
module sim_i2c_timing_monitor;

  localparam int MH = 4, ML = 8, MF = 8, MSH = 4, MSS = 4, MPS = 4;
  localparam int MDS = 3, MDH = 2, TXL = 3, TXH = 5, MP = 16, QT = 40;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, sda = 1'b1, rd = 1'b0, tx = 1'b0;
  logic [10:0] violFlags;
  logic [3:0]  violCode;
  logic        violStrobe;
  int nChecks = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_timing_monitor #(
    .MIN_HIGH(MH), .MIN_LOW(ML), .MIN_FREE(MF), .MIN_STA_HD(MSH),
    .MIN_STA_SU(MSS), .MIN_STO_SU(MPS), .MIN_DAT_SU(MDS), .MIN_DAT_HD(MDH),
    .TX_HD_MIN(TXL), .TX_HD_MAX(TXH), .MIN_PERIOD(MP), .QUIET_CYC(QT)
  ) u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .resetDone(rd),
    .localTx(tx), .violFlags(violFlags), .violCode(violCode), .violStrobe(violStrobe)
  );

  function automatic string ruleTag(input int b);
    case (b)
      0: return "R1";  1: return "R2";  2: return "R4";  3: return "R5";
      4: return "R6";  5: return "R6";  6: return "R7";  7: return "R8";
      8: return "R9";  9: return "R10"; default: return "R3";
    endcase
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; scl = 1'b1; sda = 1'b1; rd = 1'b0;
    waitN(3);
    rstN = 1'b1;
    waitN(4);
  endtask

  task automatic checkVal(input string tag, input string ctx, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, ctx, got, exp);
    end
  endtask

  task automatic checkVec(input logic [10:0] expV, input string ctx);
    nChecks++;
    if (violFlags !== expV) begin
      nBad++;
      for (int b = 0; b < 11; b++)
        if (violFlags[b] !== expV[b])
          $display("FAIL %s %s flag%0d got=%0b exp=%0b", ruleTag(b), ctx, b, violFlags[b], expV[b]);
    end
    if ($countones(expV) <= 1) begin
      int ec = 0;
      for (int b = 0; b < 11; b++) if (expV[b]) ec = b + 1;
      checkVal("R12", {ctx, " code"}, int'(violCode), ec);
    end
  endtask

  function automatic logic [10:0] expFrame(input int hi, su, hd, sts, sth, sps, bf, input bit t);
    int lo = hd + su;
    logic [10:0] v = '0;
    v[0]  = (hi < MH) || (sts + sth < MH) || (sps + bf + sth < MH);
    v[1]  = lo < ML;
    v[2]  = bf < MF;
    v[3]  = sth < MSH;
    v[4]  = (sts < MSS) || (sps + bf < MSS);
    v[5]  = sps < MPS;
    v[6]  = (su < MDS) || (su + hi + lo < MDS) || (sth + lo < MDS);
    v[7]  = !t && (hd < MDH);
    v[8]  = t && ((hd < TXL) || (hd > TXH));
    v[10] = (hi + lo < MP) || (sts + sth + lo < MP);
    return v;
  endfunction

  // START, bit, bit, repeated START, STOP, START
  task automatic runFrame(input int hi, su, hd, sts, sth, sps, bf, input bit t, input string ctx);
    int lo = hd + su;
    doReset();
    tx = t;
    sda = 1'b0; waitN(sth);
    scl = 1'b0; waitN(hd);
    sda = 1'b1; waitN(su);
    scl = 1'b1; waitN(hi);
    scl = 1'b0; waitN(lo);
    scl = 1'b1; waitN(sts);
    sda = 1'b0; waitN(sth);
    scl = 1'b0; waitN(lo);
    scl = 1'b1; waitN(sps);
    sda = 1'b1; waitN(bf);
    sda = 1'b0; waitN(sth);
    scl = 1'b0; waitN(12);
    checkVec(expFrame(hi, su, hd, sts, sth, sps, bf, t),
             $sformatf("%s hi=%0d su=%0d hd=%0d sts=%0d sth=%0d sps=%0d bf=%0d tx=%0d",
                       ctx, hi, su, hd, sts, sth, sps, bf, t));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    doReset();
    checkVal("R11", "flags after reset", int'(violFlags), 0);
    checkVal("R11", "code after reset", int'(violCode), 0);
    checkVal("R11", "strobe after reset", int'(violStrobe), 0);

    // R12: strobe timing, START hold of 1 cycle
    sda = 1'b0; waitN(1);
    scl = 1'b0;
    repeat (2) @(posedge clk); #1;
    checkVal("R12", "strobe not early", int'(violStrobe), 0);
    @(posedge clk); #1;
    checkVal("R12", "strobe on third edge", int'(violStrobe), 1);
    checkVal("R12", "code start hold", int'(violCode), 4);
    @(posedge clk); #1;
    checkVal("R12", "strobe one cycle", int'(violStrobe), 0);
    waitN(20);
    checkVal("R11", "flag stays set", int'(violFlags), 11'h008);
    doReset();
    checkVal("R11", "reset clears flags", int'(violFlags), 0);
    checkVal("R11", "reset clears code", int'(violCode), 0);

    // R12: priority when rules fire together (R1 and R5 same cycle)
    scl = 1'b0; waitN(10);
    scl = 1'b1; waitN(1);
    sda = 1'b0; waitN(1);
    scl = 1'b0; waitN(6);
    checkVal("R12", "flags priority case", int'(violFlags), 11'h019);
    checkVal("R12", "lowest code wins", int'(violCode), 1);

    // clean frame, then one-dimensional sweeps across each limit
    runFrame(8, 6, 4, 6, 6, 6, 10, 1'b0, "clean");
    for (int x = 1; x <= 9; x++)  runFrame(x, 6, 4, 6, 6, 6, 10, 1'b0, "R1 R3 high");
    for (int x = 1; x <= 9; x++)  runFrame(8, x, 4, 6, 6, 6, 10, 1'b0, "R2 R7 setup/low");
    for (int x = 1; x <= 8; x++)  runFrame(8, 6, x, 6, 6, 6, 10, 1'b0, "R8 hold");
    for (int x = 1; x <= 8; x++)  runFrame(8, 6, x, 6, 6, 6, 10, 1'b1, "R9 tx hold");
    for (int x = 1; x <= 7; x++)  runFrame(8, 6, 4, x, 6, 6, 10, 1'b0, "R6 start setup");
    for (int x = 1; x <= 7; x++)  runFrame(8, 6, 4, 6, x, 6, 10, 1'b0, "R5 start hold");
    for (int x = 1; x <= 7; x++)  runFrame(8, 6, 4, 6, 6, x, 10, 1'b0, "R6 stop setup");
    for (int x = 1; x <= 11; x++) runFrame(8, 6, 4, 6, 6, 6, x, 1'b0, "R4 bus free");
    for (int h = 2; h <= 8; h++)
      for (int s = 2; s <= 8; s++) runFrame(h, s, 3, 6, 6, 6, 10, 1'b0, "R3 period grid");

    // R10: START distance from resetDone pulse
    for (int q = QT - 3; q <= QT + 2; q++) begin
      doReset();
      tx = 1'b0;
      rd = 1'b1; waitN(1);
      rd = 1'b0; waitN(q - 1);
      sda = 1'b0; waitN(10);
      sda = 1'b1; waitN(8);
      checkVec((q < QT) ? 11'h200 : 11'h000, $sformatf("R10 quiet q=%0d", q));
    end

    // R10: no pulse yet, early START is not flagged
    doReset();
    sda = 1'b0; waitN(10);
    checkVec(11'h000, "R10 no pulse");

    done = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule